// File: doc/BRIEF.md
# Digital Potentiometer Command Decoder

This block sits behind a byte-level two-wire slave front end and turns the master's command bytes into register operations for a digital potentiometer. The front end gives it framing pulses for start and stop, each byte the master writes, and a request each time the master wants to read a byte. The block holds a 10-bit volatile wiper latch, four 10-bit data registers treated as non-volatile, and a busy flag that models the write time of non-volatile storage.

A transaction opens with an identification byte. Its top four bits carry a device-type code, its two address bits are compared with the strapped address pins, and its lowest bit picks read (1) or write (0) mode. A matching device acknowledges and then takes an instruction byte that holds a 3-bit opcode and a 2-bit register pointer. Writes carry a 10-bit value as a high byte and then a low byte. Reads return the value the same way, one byte for each request. Copies between the wiper latch and a data register take effect as soon as the instruction byte is accepted.

Top module: `potcmd_decoder`

## Requirements
- R1: `ack_addr` pulses for one cycle, one cycle after an identification byte, only when byte bits [7:4] = 0101, bit 3 = 0 and bits [2:1] equal `strap_addr`. Bit 0 is the mode: 1 = read, 0 = write.
- R2: When the identification byte does not match, every later byte of that transaction gets no acknowledge and changes no register.
- R3: The instruction byte has its opcode in bits [7:5] and its register pointer in bits [3:2]. Pointer 0..3 selects data register 0..3. A legal instruction is acknowledged on `ack_data` one cycle after the byte.
- R4: Opcode 001 in write mode writes the wiper latch. The first data byte supplies value bits 9:8 from its bits [1:0], the second supplies bits 7:0, and each data byte is acknowledged. Opcode 000 in read mode reads the latch back. `wiper_pos` always shows the latch.
- R5: Opcode 011 in write mode writes the selected data register. Opcode 010 in read mode reads it. The other registers are unchanged.
- R6: Opcode 100 (write mode) copies the selected data register into the wiper latch. Opcode 101 (write mode) copies the wiper latch into the selected data register.
- R7: A data-register write or a latch-to-register copy raises `wip` for exactly WIP_CYCLES cycles. Opcode 110 in read mode returns a byte whose bit 0 is `wip` and whose other bits are 0.
- R8: While `wip` is 1, opcodes 011 and 101 are not acknowledged and change no register.
- R9: In read mode each `rd_req` produces `rd_valid` with `rd_byte` one cycle later. The bytes alternate high byte (bits 9:8 in [1:0]) and low byte. Opcode 111, and any opcode used in the wrong mode, is not acknowledged.
- R10: After reset the wiper latch and all data registers are 0, and `wip`, `ack_addr`, `ack_data` and `rd_valid` are 0.
- R11: A write commits only when its second data byte arrives. A stop after the first data byte leaves the target unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_addr | input | 2 | Strapped device address |
| start | input | 1 | Start condition seen, one-cycle pulse |
| stop | input | 1 | Stop condition seen, one-cycle pulse |
| byte_valid | input | 1 | A byte written by the master is on byte_in |
| byte_in | input | 8 | Byte written by the master |
| rd_req | input | 1 | Master requests the next read byte |
| ack_addr | output | 1 | Identification byte matched |
| ack_data | output | 1 | Instruction or data byte accepted |
| rd_valid | output | 1 | rd_byte holds a byte for the master |
| rd_byte | output | 8 | Byte returned to the master |
| wip | output | 1 | Non-volatile write in progress |
| wiper_pos | output | VAL_W | Current wiper latch value |

## Verification
A wrong sequencer state shows up at the acknowledge outputs in the cycle after the next byte: an acknowledge is missing or one appears where none should. Corrupted register contents show up only when the register is read back, or at once on `wiper_pos` for the latch, so every write and copy is followed by a read of its target and of a neighbour it must not touch. A busy timer that runs too long or too short is measured cycle by cycle on `wip` and is also seen when a data-register write is refused or accepted.

// File: rtl/potcmd_pkg.sv
// Package: shared constants and types for the potentiometer command decoder.
// Assumes: values are 9 to 16 bits wide and travel as two bytes.
package potcmd_pkg;

    localparam logic [3:0] DEV_TYPE = 4'b0101;

    typedef enum logic [2:0] {
        OP_RD_WL  = 3'b000,
        OP_WR_WL  = 3'b001,
        OP_RD_DR  = 3'b010,
        OP_WR_DR  = 3'b011,
        OP_DR2WL  = 3'b100,
        OP_WL2DR  = 3'b101,
        OP_RD_ST  = 3'b110,
        OP_RSVD   = 3'b111
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ID,
        ST_INSTR,
        ST_WHI,
        ST_WLO,
        ST_RD
    } state_e;

endpackage

// File: rtl/potcmd_id_match.sv
// Module: compares an identification byte with the device-type code and
// the strapped address pins, and extracts the read/write mode bit.
// Assumes: purely combinational; the caller qualifies it with byte_valid.
module potcmd_id_match
    import potcmd_pkg::*;
(
    input  logic [7:0] id_byte,
    input  logic [1:0] strap,
    output logic       match,
    output logic       rd_mode
);

    // Match when type, the fixed zero bit and both address bits agree.
    always_comb begin
        match   = (id_byte[7:4] == DEV_TYPE) && (id_byte[3] == 1'b0)
                  && (id_byte[2:1] == strap);
        rd_mode = id_byte[0];
    end

endmodule

// File: rtl/potcmd_instr_dec.sv
// Module: splits an instruction byte into opcode and register pointer and
// decides whether the instruction may run in the current mode and busy state.
// Assumes: IDX_W pointer bits sit directly above the two low reserved bits.
module potcmd_instr_dec
    import potcmd_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input  logic [7:0]       instr,
    input  logic             rd_mode,
    input  logic             busy,
    output op_e              op,
    output logic [IDX_W-1:0] idx,
    output logic             legal,
    output logic             takes_data,
    output logic             is_read
);

    // Field extraction.
    always_comb begin
        op  = op_e'(instr[7:5]);
        idx = instr[2+IDX_W-1:2];
    end

    // Legality: mode must fit the opcode; writes into storage wait for busy.
    always_comb begin
        legal      = 1'b0;
        takes_data = 1'b0;
        is_read    = 1'b0;
        case (op)
            OP_RD_WL, OP_RD_DR, OP_RD_ST: begin
                legal   = rd_mode;
                is_read = 1'b1;
            end
            OP_WR_WL: begin
                legal      = !rd_mode;
                takes_data = 1'b1;
            end
            OP_DR2WL: legal = !rd_mode;
            OP_WR_DR: begin
                legal      = !rd_mode && !busy;
                takes_data = 1'b1;
            end
            OP_WL2DR: legal = !rd_mode && !busy;
            default:  legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/potcmd_regs.sv
// Module: wiper latch, data registers and the write-busy timer.
// Assumes: one write port per register class; any data-register write
// starts a busy window of WIP_CYCLES cycles.
module potcmd_regs #(
    parameter int VAL_W      = 10,
    parameter int NUM_DR     = 4,
    parameter int WIP_CYCLES = 64
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wl_we,
    input  logic [VAL_W-1:0]          wl_d,
    input  logic                      dr_we,
    input  logic [$clog2(NUM_DR)-1:0] idx,
    input  logic [VAL_W-1:0]          dr_d,
    output logic [VAL_W-1:0]          wl_q,
    output logic [VAL_W-1:0]          dr_q,
    output logic                      busy
);

    localparam int IDX_W = $clog2(NUM_DR);
    localparam int CNT_W = $clog2(WIP_CYCLES + 1);

    logic [VAL_W-1:0] dr_mem [NUM_DR];
    logic [CNT_W-1:0] cnt;

    // Volatile wiper latch.
    always_ff @(posedge clk) begin
        if (!rst_n)     wl_q <= '0;
        else if (wl_we) wl_q <= wl_d;
    end

    // One storage register per data-register slot.
    for (genvar g = 0; g < NUM_DR; g++) begin : g_dr
        always_ff @(posedge clk) begin
            if (!rst_n)                                dr_mem[g] <= '0;
            else if (dr_we && (idx == IDX_W'(g)))      dr_mem[g] <= dr_d;
        end
    end

    // Selected register for reads and copies.
    always_comb dr_q = dr_mem[idx];

    // Busy window: loads on a write, counts down, clears at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (dr_we) begin
            busy <= 1'b1;
            cnt  <= CNT_W'(WIP_CYCLES - 1);
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
        end
    end

endmodule

// File: rtl/potcmd_decoder.sv
// Module: top of the command decoder. Sequences identification byte,
// instruction byte and data bytes, drives acknowledges and read bytes.
// Assumes: the front end presents at most one of start, stop, byte_valid
// or rd_req per cycle; start wins over everything, stop over bytes.
module potcmd_decoder
    import potcmd_pkg::*;
#(
    parameter int VAL_W      = 10,
    parameter int NUM_DR     = 4,
    parameter int WIP_CYCLES = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       strap_addr,
    input  logic             start,
    input  logic             stop,
    input  logic             byte_valid,
    input  logic [7:0]       byte_in,
    input  logic             rd_req,
    output logic             ack_addr,
    output logic             ack_data,
    output logic             rd_valid,
    output logic [7:0]       rd_byte,
    output logic             wip,
    output logic [VAL_W-1:0] wiper_pos
);

    localparam int IDX_W = $clog2(NUM_DR);
    localparam int HI_W  = VAL_W - 8;

    state_e           state;
    logic             rd_mode_q;
    op_e              op_q;
    logic [IDX_W-1:0] idx_q;
    logic [HI_W-1:0]  hi_q;
    logic             rd_phase;

    logic             id_ok, id_rd;
    op_e              dec_op;
    logic [IDX_W-1:0] dec_idx;
    logic             dec_legal, dec_data, dec_read;

    logic             byte_go;
    logic             instr_go;
    logic             commit;
    logic             wl_we, dr_we;
    logic [VAL_W-1:0] wl_d, dr_d;
    logic [IDX_W-1:0] reg_idx;
    logic [VAL_W-1:0] wl_q, dr_q;
    logic [VAL_W-1:0] full_val;
    logic [VAL_W-1:0] rd_src;

    potcmd_id_match u_id (
        .id_byte (byte_in),
        .strap   (strap_addr),
        .match   (id_ok),
        .rd_mode (id_rd)
    );

    potcmd_instr_dec #(.IDX_W(IDX_W)) u_dec (
        .instr      (byte_in),
        .rd_mode    (rd_mode_q),
        .busy       (wip),
        .op         (dec_op),
        .idx        (dec_idx),
        .legal      (dec_legal),
        .takes_data (dec_data),
        .is_read    (dec_read)
    );

    potcmd_regs #(
        .VAL_W      (VAL_W),
        .NUM_DR     (NUM_DR),
        .WIP_CYCLES (WIP_CYCLES)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wl_we (wl_we),
        .wl_d  (wl_d),
        .dr_we (dr_we),
        .idx   (reg_idx),
        .dr_d  (dr_d),
        .wl_q  (wl_q),
        .dr_q  (dr_q),
        .busy  (wip)
    );

    // A byte counts only when no framing event overrides it this cycle.
    always_comb begin
        byte_go  = byte_valid && !start && !stop;
        instr_go = byte_go && (state == ST_INSTR) && dec_legal;
        commit   = byte_go && (state == ST_WLO);
    end

    // Register index: decoded pointer during the instruction, captured after.
    always_comb reg_idx = (state == ST_INSTR) ? dec_idx : idx_q;

    // Assembled write value from the held high bits and the current byte.
    always_comb full_val = {hi_q, byte_in};

    // Write strobes for commits and copies.
    always_comb begin
        wl_we = 1'b0;
        dr_we = 1'b0;
        wl_d  = full_val;
        dr_d  = full_val;
        if (commit && (op_q == OP_WR_WL)) wl_we = 1'b1;
        if (commit && (op_q == OP_WR_DR)) dr_we = 1'b1;
        if (instr_go && (dec_op == OP_DR2WL)) begin
            wl_we = 1'b1;
            wl_d  = dr_q;
        end
        if (instr_go && (dec_op == OP_WL2DR)) begin
            dr_we = 1'b1;
            dr_d  = wl_q;
        end
    end

    // Source value for register reads.
    always_comb rd_src = (op_q == OP_RD_WL) ? wl_q : dr_q;

    // Transaction sequencer with registered acknowledges and read bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            rd_mode_q <= 1'b0;
            op_q      <= OP_RSVD;
            idx_q     <= '0;
            hi_q      <= '0;
            rd_phase  <= 1'b0;
            ack_addr  <= 1'b0;
            ack_data  <= 1'b0;
            rd_valid  <= 1'b0;
            rd_byte   <= '0;
        end else begin
            ack_addr <= 1'b0;
            ack_data <= 1'b0;
            rd_valid <= 1'b0;
            if (start) begin
                state    <= ST_ID;
                rd_phase <= 1'b0;
            end else if (stop) begin
                state <= ST_IDLE;
            end else begin
                case (state)
                    ST_ID: if (byte_valid) begin
                        if (id_ok) begin
                            ack_addr  <= 1'b1;
                            rd_mode_q <= id_rd;
                            state     <= ST_INSTR;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                    ST_INSTR: if (byte_valid) begin
                        if (dec_legal) begin
                            ack_data <= 1'b1;
                            op_q     <= dec_op;
                            idx_q    <= dec_idx;
                            if (dec_data)      state <= ST_WHI;
                            else if (dec_read) state <= ST_RD;
                            else               state <= ST_IDLE;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                    ST_WHI: if (byte_valid) begin
                        ack_data <= 1'b1;
                        hi_q     <= byte_in[HI_W-1:0];
                        state    <= ST_WLO;
                    end
                    ST_WLO: if (byte_valid) begin
                        ack_data <= 1'b1;
                        state    <= ST_IDLE;
                    end
                    ST_RD: if (rd_req) begin
                        rd_valid <= 1'b1;
                        rd_phase <= !rd_phase;
                        if (op_q == OP_RD_ST)
                            rd_byte <= {7'b0, wip};
                        else if (!rd_phase)
                            rd_byte <= {{(16 - VAL_W){1'b0}}, rd_src[VAL_W-1:8]};
                        else
                            rd_byte <= rd_src[7:0];
                    end
                    default: ;
                endcase
            end
        end
    end

    // Wiper position to the resistor array.
    always_comb wiper_pos = wl_q;

endmodule

// File: rtl/potcmd_decoder_chk.sv
// Module: property checker for potcmd_decoder, attached by bind.
// Assumes: sees ports plus the internal write strobes of the top.
module potcmd_decoder_chk #(
    parameter int VAL_W      = 10,
    parameter int WIP_CYCLES = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       strap_addr,
    input logic             byte_valid,
    input logic [7:0]       byte_in,
    input logic             rd_req,
    input logic             ack_addr,
    input logic             ack_data,
    input logic             rd_valid,
    input logic             wip,
    input logic [VAL_W-1:0] wiper_pos,
    input logic             wl_we,
    input logic             dr_we
);

    localparam int CNT_W = $clog2(WIP_CYCLES + 2);
    logic [CNT_W-1:0] busy_run;

    // Length of the current busy run, for the window check.
    always_ff @(posedge clk) begin
        if (!rst_n)    busy_run <= '0;
        else if (!wip) busy_run <= '0;
        else           busy_run <= busy_run + 1'b1;
    end

    AST_ADDR_ACK_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        ack_addr |-> ($past(byte_valid) && ($past(byte_in[7:3]) == 5'b01010)
                      && ($past(byte_in[2:1]) == $past(strap_addr)))); // R1

    AST_ACK_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack_addr && ack_data)); // R3

    AST_DATA_ACK_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_data |-> $past(byte_valid)); // R3

    AST_RD_ONLY_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_req)); // R9

    AST_WIP_ON_DR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        dr_we |=> wip); // R7

    AST_NO_DR_WRITE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        wip |-> !dr_we); // R8

    AST_WIPER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wl_we |=> $stable(wiper_pos)); // R11

    AST_WIP_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run <= CNT_W'(WIP_CYCLES)); // R7

endmodule

bind potcmd_decoder potcmd_decoder_chk #(
    .VAL_W      (VAL_W),
    .WIP_CYCLES (WIP_CYCLES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .strap_addr (strap_addr),
    .byte_valid (byte_valid),
    .byte_in    (byte_in),
    .rd_req     (rd_req),
    .ack_addr   (ack_addr),
    .ack_data   (ack_data),
    .rd_valid   (rd_valid),
    .wip        (wip),
    .wiper_pos  (wiper_pos),
    .wl_we      (wl_we),
    .dr_we      (dr_we)
);

// File: tb/potcmd_decoder_test.sv
// Bench: vector table of transactions, then directed corner cases.
module potcmd_decoder_test;

    localparam int VAL_W = 10;
    localparam int WIPC  = 16;
    localparam int NV    = 14;
    localparam logic [7:0] ID_WR = 8'h54;  // type 0101, 0, addr 10, write
    localparam logic [7:0] ID_RD = 8'h55;  // same, read

    // {rd_mode, instr, write data, expected instr ack, expected read value}
    localparam logic [29:0] VEC [NV] = '{
        {1'b0, 8'h20, 10'h2A5, 1'b1, 10'h000},  // R4 write wiper
        {1'b1, 8'h00, 10'h000, 1'b1, 10'h2A5},  // R4 read wiper
        {1'b0, 8'h64, 10'h13C, 1'b1, 10'h000},  // R5 write DR1
        {1'b1, 8'h44, 10'h000, 1'b1, 10'h13C},  // R5 read DR1
        {1'b1, 8'h40, 10'h000, 1'b1, 10'h000},  // R5 DR0 untouched
        {1'b0, 8'hAC, 10'h000, 1'b1, 10'h000},  // R6 wiper to DR3
        {1'b1, 8'h4C, 10'h000, 1'b1, 10'h2A5},  // R6 read DR3
        {1'b0, 8'h84, 10'h000, 1'b1, 10'h000},  // R6 DR1 to wiper
        {1'b1, 8'h00, 10'h000, 1'b1, 10'h13C},  // R6 read wiper
        {1'b0, 8'hE0, 10'h000, 1'b0, 10'h000},  // R9 reserved opcode
        {1'b0, 8'h00, 10'h000, 1'b0, 10'h000},  // R9 read opcode in write mode
        {1'b1, 8'hC0, 10'h000, 1'b1, 10'h000},  // R7 status idle
        {1'b0, 8'h68, 10'h3FF, 1'b1, 10'h000},  // R5 write DR2
        {1'b1, 8'h48, 10'h000, 1'b1, 10'h3FF}   // R5 read DR2
    };

    logic             clk = 1'b0;
    logic             rst_n;
    logic [1:0]       strap_addr;
    logic             start, stop, byte_valid, rd_req;
    logic [7:0]       byte_in;
    logic             ack_addr, ack_data, rd_valid, wip;
    logic [7:0]       rd_byte;
    logic [VAL_W-1:0] wiper_pos;

    int n_chk  = 0;
    int n_fail = 0;
    logic done = 1'b0;

    always #4 clk = !clk;  // 125 MHz

    potcmd_decoder #(.VAL_W(VAL_W), .NUM_DR(4), .WIP_CYCLES(WIPC)) uut (
        .clk(clk), .rst_n(rst_n), .strap_addr(strap_addr), .start(start),
        .stop(stop), .byte_valid(byte_valid), .byte_in(byte_in),
        .rd_req(rd_req), .ack_addr(ack_addr), .ack_data(ack_data),
        .rd_valid(rd_valid), .rd_byte(rd_byte), .wip(wip),
        .wiper_pos(wiper_pos)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_start();
        start = 1'b1; @(negedge clk); start = 1'b0;
    endtask

    task automatic do_stop();
        stop = 1'b1; @(negedge clk); stop = 1'b0;
    endtask

    // Drive one byte for one cycle; acknowledges are visible on return.
    task automatic send(input logic [7:0] b);
        byte_in = b; byte_valid = 1'b1; @(negedge clk); byte_valid = 1'b0;
    endtask

    // Request one read byte; rd_valid and rd_byte are visible on return.
    task automatic rd(output logic [7:0] b, output logic v);
        rd_req = 1'b1; @(negedge clk); rd_req = 1'b0;
        b = rd_byte; v = rd_valid;
    endtask

    // Full read of a register: two bytes, returns the value.
    task automatic read_reg(input logic [7:0] instr, output logic [9:0] val);
        logic [7:0] b1, b2;
        logic v1, v2;
        do_start(); send(ID_RD); send(instr);
        rd(b1, v1); rd(b2, v2);
        do_stop();
        val = {b1[1:0], b2};
    endtask

    task automatic write_reg(input logic [7:0] instr, input logic [9:0] val);
        do_start(); send(ID_WR); send(instr);
        send({6'b0, val[9:8]}); send(val[7:0]);
        do_stop();
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : main
        logic [29:0] e;
        logic [7:0]  b;
        logic        v;
        logic [9:0]  val;
        int          cnt;
        string       tag;

        rst_n = 1'b0; strap_addr = 2'b10; start = 0; stop = 0;
        byte_valid = 0; rd_req = 0; byte_in = '0;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        chk(!ack_addr && !ack_data && !rd_valid, "R10 acks", {ack_addr, ack_data, rd_valid}, 0);
        chk(!wip, "R10 wip", wip, 0);
        chk(wiper_pos == '0, "R10 wiper", wiper_pos, 0);
        read_reg(8'h4C, val);
        chk(val == 10'h0, "R10 DR3", val, 0);

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            e = VEC[i];
            case (e[28:26])
                3'b000, 3'b001: tag = "R4";
                3'b010, 3'b011: tag = "R5";
                3'b100, 3'b101: tag = "R6";
                3'b110:         tag = "R7";
                default:        tag = "R9";
            endcase
            do_start();
            send(e[29] ? ID_RD : ID_WR);
            chk(ack_addr, "R1 id ack", ack_addr, 1);
            send(e[28:21]);
            chk(ack_data == e[10], {tag, " instr ack (R3)"}, ack_data, e[10]);
            if (e[10] && !e[29] && (e[26] == 1'b1) && (e[28] == 1'b0)) begin
                send({6'b0, e[20:19]});
                chk(ack_data, {tag, " data hi ack"}, ack_data, 1);
                send(e[18:11]);
                chk(ack_data, {tag, " data lo ack"}, ack_data, 1);
            end
            if (e[10] && e[29]) begin
                rd(b, v);
                if (e[28:26] == 3'b110)
                    chk(v && b == e[7:0], {tag, " status (R9)"}, b, e[7:0]);
                else
                    chk(v && b == {6'b0, e[9:8]}, {tag, " read hi (R9)"}, b, e[9:8]);
                rd(b, v);
                chk(v && b == e[7:0], {tag, " read lo (R9)"}, b, e[7:0]);
            end
            do_stop();
            idle(WIPC + 4);
        end
        chk(wiper_pos == 10'h13C, "R4 wiper_pos port", wiper_pos, 10'h13C);

        // R1 wrong address and wrong type: no ack; R2 rest ignored
        do_start(); send(8'h56);
        chk(!ack_addr, "R1 wrong address", ack_addr, 0);
        send(8'h20);
        chk(!ack_data, "R2 instr ignored", ack_data, 0);
        send(8'h00); send(8'h11);
        chk(!ack_data, "R2 data ignored", ack_data, 0);
        do_stop();
        chk(wiper_pos == 10'h13C, "R2 wiper unchanged", wiper_pos, 10'h13C);
        do_start(); send(8'h74);
        chk(!ack_addr, "R1 wrong type", ack_addr, 0);
        do_stop();

        // R11 partial write then stop
        do_start(); send(ID_WR); send(8'h20); send(8'h03); do_stop();
        chk(wiper_pos == 10'h13C, "R11 partial write", wiper_pos, 10'h13C);

        // R7 busy window length
        write_reg(8'h60, 10'h155);
        // write_reg ends one cycle after commit: wip already high two samples
        cnt = 2;
        chk(wip, "R7 wip set", wip, 1);
        for (int k = 0; k < 100 && wip; k++) begin
            @(negedge clk);
            if (wip) cnt++;
        end
        chk(cnt == WIPC, "R7 wip length", cnt, WIPC);
        idle(2);

        // R8 rejected writes while busy, R7 status shows busy
        write_reg(8'h64, 10'h0AA);
        do_start(); send(ID_RD); send(8'hC0); rd(b, v); do_stop();
        chk(v && b == 8'h01, "R7 status busy", b, 1);
        do_start(); send(ID_WR); send(8'h60);
        chk(!ack_data, "R8 DR write refused", ack_data, 0);
        do_stop();
        do_start(); send(ID_WR); send(8'hA0);
        chk(!ack_data, "R8 copy refused", ack_data, 0);
        do_stop();
        idle(WIPC + 4);
        read_reg(8'h40, val);
        chk(val == 10'h155, "R8 DR0 kept", val, 10'h155);
        read_reg(8'h44, val);
        chk(val == 10'h0AA, "R5 DR1 rewritten", val, 10'h0AA);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule